// File: doc/BRIEF.md
# UART Transmitter with RS485 Driver-Enable Timing

This block serialises data words onto an asynchronous serial line and drives the driver-enable pin of an RS485 transceiver around each frame. Each frame has one low start bit, a data word of 7, 8 or 9 bits sent least significant bit first, an optional parity bit that takes the place of the word's top bit, and one or two high stop bits. The line rests high. A baud divisor input sets the bit period in clock cycles. The driver-enable output rises a programmable number of cycles before the start bit. It falls a second programmable number of cycles after the last stop bit.

Software writes words through a valid/ready handshake into a one-word holding register. A global enable and a transmitter enable control the engine. When the global enable is low, the engine silences its outputs in the same cycle and discards all work in flight. The format and timing fields are captured only while the global enable is low. A rising transmitter enable, including the one that follows enable, does two things: after one bit period it raises an acknowledge, and it queues a full idle frame. That frame goes out after any frame already in progress. A completion flag shows that the line has drained.

Top module: `uart_tx_de`

## Requirements
- R1: A frame starts with one low start bit, followed by the data word, least significant bit first. The 2-bit word-length code gives 8 data bits for 00, 9 for 01, 7 for 10 and 8 for 11.
- R2: When parity is on, the word's top position (bit 8 for code 01, bit 7 for 00, bit 6 for 10) carries the parity bit in place of the data bit. With the odd select at 0 this bit makes the number of ones in the word even. With the odd select at 1 it makes that number odd.
- R3: One stop bit follows the word when the two-stop input is 0, and two stop bits follow when it is 1. Both stop bits are high.
- R4: Every bit lasts baud_div_i clock cycles. A divisor of 0 acts as 1.
- R5: de_o rises exactly de_lead_i cycles before tx_o falls for the start bit. A lead of 0 means the two change together.
- R6: de_o stays high for exactly de_lag_i cycles after the last stop bit ends.
- R7: A word that is waiting when a frame ends is sent as follows. de_o first completes its lag, then drops for exactly one cycle, then runs a full new lead before the next start bit.
- R8: tx_en_ack_o rises baud_div_i cycles after the first clock edge that sees tx_en_i high, and it falls at the first edge that sees tx_en_i low. No frame starts while the acknowledge is low, and a word written then is held.
- R9: Each rising tx_en_i queues an idle frame. This frame holds tx_o high with de_o low for one frame length of bit periods. It is sent after the current frame and before the next data frame. The driver-enable gap between the two data frames is then frame_bits*baud+2 cycles.
- R10: tx_done_o rises at the edge where the last stop bit ends, provided no word is waiting. The edge that accepts a write clears it.
- R11: While en_i is low, tx_o is high and de_o, tx_en_ack_o, tx_done_o and wr_ready_o are low in the same cycle. The frame in progress and any waiting word are discarded.
- R12: Word length, parity, stop count, divisor and driver-enable times are captured only while en_i is low. Changes to them while en_i is high have no effect.
- R13: wr_ready_o is high when en_i is high and no word is waiting. A word is taken at a clock edge where wr_valid_i and wr_ready_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable |
| tx_en_i | input | 1 | Transmitter enable |
| word_len_i | input | 2 | Word-length code |
| par_en_i | input | 1 | Parity on |
| par_odd_i | input | 1 | Odd parity select |
| two_stop_i | input | 1 | Two stop bits |
| de_lead_i | input | DE_W | Driver-enable lead, in cycles |
| de_lag_i | input | DE_W | Driver-enable lag, in cycles |
| baud_div_i | input | DIV_W | Bit period, in cycles |
| wr_valid_i | input | 1 | Write request |
| wr_data_i | input | 9 | Write data |
| wr_ready_o | output | 1 | Holding register free |
| tx_o | output | 1 | Serial line |
| de_o | output | 1 | Transceiver driver enable |
| tx_en_ack_o | output | 1 | Transmitter enable acknowledge |
| tx_done_o | output | 1 | Transmission complete |

## Verification
Results fall due at fixed distances from a stimulus, so every check counts falling-edge samples from an event the bench has already seen. The acknowledge is first seen baud+1 samples after tx_en_i is driven high. Once de_o is seen high, the start bit appears after exactly lead samples. Bit k spans samples k*baud through k*baud+baud-1, measured from the first start-bit sample, and the bench reads both ends of each bit. The completion flag is read at sample frame_bits*baud, and de_o must then stay high for exactly lag further samples. The low gap before the next frame is counted and must be 1, or frame_bits*baud+2 when an idle frame is queued. The effects of disable are read 1 ns after the drive, before any clock edge.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = 12;
  localparam int LEN_W   = 4;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_LAG} tx_state_e;

  typedef struct packed {
    logic [1:0] wl;
    logic       pen;
    logic       podd;
    logic       two_stop;
  } fmt_cfg_t;

  function automatic logic [LEN_W-1:0] word_bits(input logic [1:0] wl);
    case (wl)
      2'b01:   return LEN_W'(9);
      2'b10:   return LEN_W'(7);
      default: return LEN_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data_i,
  input  fmt_cfg_t           fmt_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   flen_o
);
  logic [LEN_W-1:0] w;
  logic             par;

  always_comb begin
    w       = word_bits(fmt_i.wl);
    par     = fmt_i.podd;
    frame_o = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(w) - 1) par = par ^ data_i[i];
    end
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(w)) begin
        frame_o[i+1] = (fmt_i.pen && i == int'(w) - 1) ? par : data_i[i];
      end
    end
    flen_o = w + (fmt_i.two_stop ? LEN_W'(3) : LEN_W'(2));
  end
endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  logic [DIV_W-1:0] cnt_q, div_m1;

  assign div_m1 = (div_i == '0) ? '0 : div_i - ONE;
  assign tick_o = run_i && (cnt_q == div_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/uart_tx_en_ctrl.sv
module uart_tx_en_ctrl #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tx_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             idle_done_i,
  output logic             ack_o,
  output logic             idle_req_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  logic             te_q, busy_q, ack_q, idle_q;
  logic [DIV_W-1:0] dly_q, div_m1;

  assign div_m1     = (div_i == '0) ? '0 : div_i - ONE;
  assign ack_o      = ack_q;
  assign idle_req_o = idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      te_q <= 1'b0; busy_q <= 1'b0; ack_q <= 1'b0; idle_q <= 1'b0; dly_q <= '0;
    end else if (!en_i) begin
      te_q <= 1'b0; busy_q <= 1'b0; ack_q <= 1'b0; idle_q <= 1'b0; dly_q <= '0;
    end else begin
      te_q <= tx_en_i;
      if (tx_en_i && !te_q) begin
        // rising enable: restart the one-bit delay and queue an idle frame
        ack_q  <= 1'b0;
        busy_q <= 1'b1;
        dly_q  <= div_m1;
        idle_q <= 1'b1;
      end else begin
        if (!tx_en_i) begin
          ack_q  <= 1'b0;
          busy_q <= 1'b0;
        end else if (busy_q) begin
          if (dly_q == '0) begin
            ack_q  <= 1'b1;
            busy_q <= 1'b0;
          end else begin
            dly_q <= dly_q - ONE;
          end
        end
        if (idle_done_i) idle_q <= 1'b0;
      end
    end
  end

  assert_ack_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tx_en_i) |=> !ack_q);
endmodule

// File: rtl/uart_tx_de.sv
module uart_tx_de
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tx_en_i,
  input  logic [1:0]        word_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  input  logic [DE_W-1:0]   de_lead_i,
  input  logic [DE_W-1:0]   de_lag_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  output logic              tx_o,
  output logic              de_o,
  output logic              tx_en_ack_o,
  output logic              tx_done_o
);
  localparam logic [DE_W-1:0]  DE_ONE  = DE_W'(1);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  fmt_cfg_t           fmt_q;
  logic [DE_W-1:0]    lead_q, lag_q, cnt_q;
  logic [DIV_W-1:0]   div_q;
  tx_state_e          state_q;
  logic               tx_q, de_q, pend_q, tc_q, idle_frm_q;
  logic [DATA_W-1:0]  hold_q;
  logic [FRAME_W-1:0] sh_q, frame;
  logic [LEN_W-1:0]   bits_q, flen;
  logic               ack, idle_req, idle_done, tick, wr_acc;

  // configuration capture, only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q <= '0; lead_q <= '0; lag_q <= '0; div_q <= '0;
    end else if (!en_i) begin
      fmt_q  <= '{wl: word_len_i, pen: par_en_i, podd: par_odd_i, two_stop: two_stop_i};
      lead_q <= de_lead_i;
      lag_q  <= de_lag_i;
      div_q  <= baud_div_i;
    end
  end

  uart_tx_framer u_framer (
    .data_i (hold_q),
    .fmt_i  (fmt_q),
    .frame_o(frame),
    .flen_o (flen)
  );

  uart_tx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == S_SHIFT),
    .div_i (div_q),
    .tick_o(tick)
  );

  assign idle_done = en_i && (state_q == S_IDLE) && ack && idle_req;

  uart_tx_en_ctrl #(.DIV_W(DIV_W)) u_en_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tx_en_i    (tx_en_i),
    .div_i      (div_q),
    .idle_done_i(idle_done),
    .ack_o      (ack),
    .idle_req_o (idle_req)
  );

  assign wr_ready_o  = en_i && !pend_q;
  assign wr_acc      = wr_valid_i && wr_ready_o;
  assign tx_o        = tx_q | ~en_i;
  assign de_o        = de_q & en_i;
  assign tx_en_ack_o = ack & en_i;
  assign tx_done_o   = tc_q & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; tx_q <= 1'b1; de_q <= 1'b0; pend_q <= 1'b0; tc_q <= 1'b0;
      idle_frm_q <= 1'b0; hold_q <= '0; sh_q <= '1; bits_q <= '0; cnt_q <= '0;
    end else if (!en_i) begin
      state_q <= S_IDLE; tx_q <= 1'b1; de_q <= 1'b0; pend_q <= 1'b0; tc_q <= 1'b0;
      idle_frm_q <= 1'b0; sh_q <= '1; bits_q <= '0; cnt_q <= '0;
    end else begin
      if (wr_acc) begin
        pend_q <= 1'b1;
        hold_q <= wr_data_i;
        tc_q   <= 1'b0;
      end
      unique case (state_q)
        S_IDLE: begin
          if (ack && idle_req) begin
            state_q    <= S_SHIFT;
            idle_frm_q <= 1'b1;
            sh_q       <= '1;
            bits_q     <= flen - LEN_ONE;
          end else if (ack && tx_en_i && pend_q) begin
            pend_q     <= 1'b0;
            de_q       <= 1'b1;
            idle_frm_q <= 1'b0;
            if (lead_q == '0) begin
              tx_q    <= frame[0];
              sh_q    <= {1'b1, frame[FRAME_W-1:1]};
              bits_q  <= flen - LEN_ONE;
              state_q <= S_SHIFT;
            end else begin
              sh_q    <= frame;
              cnt_q   <= lead_q - DE_ONE;
              state_q <= S_LEAD;
            end
          end
        end
        S_LEAD: begin
          if (cnt_q == '0) begin
            tx_q    <= sh_q[0];
            sh_q    <= {1'b1, sh_q[FRAME_W-1:1]};
            bits_q  <= flen - LEN_ONE;
            state_q <= S_SHIFT;
          end else begin
            cnt_q <= cnt_q - DE_ONE;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            if (bits_q == '0) begin
              tx_q <= 1'b1;
              if (idle_frm_q) begin
                idle_frm_q <= 1'b0;
                state_q    <= S_IDLE;
              end else begin
                if (!pend_q && !wr_acc) tc_q <= 1'b1;
                if (lag_q == '0) begin
                  de_q    <= 1'b0;
                  state_q <= S_IDLE;
                end else begin
                  cnt_q   <= lag_q - DE_ONE;
                  state_q <= S_LAG;
                end
              end
            end else begin
              tx_q   <= sh_q[0];
              sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
              bits_q <= bits_q - LEN_ONE;
            end
          end
        end
        S_LAG: begin
          if (cnt_q == '0) begin
            de_q    <= 1'b0;
            state_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q - DE_ONE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_tx_low_needs_de_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_o |-> de_o);
  assert_frame_needs_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_q) |-> $past(ack));
  assert_write_clears_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o) |=> !tx_done_o);
  assert_disable_discards_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == S_IDLE && !pend_q && !tc_q));
endmodule

// File: tb/uart_tx_de_bench.sv
module uart_tx_de_bench;
  localparam int DIV_W = 8;
  localparam int DE_W  = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic en = 0, tx_en = 0, par_en = 0, par_odd = 0, two_stop = 0, wr_valid = 0;
  logic [1:0] word_len = 0;
  logic [DE_W-1:0] de_lead = 0, de_lag = 0;
  logic [DIV_W-1:0] baud_div = 1;
  logic [8:0] wr_data = 0;
  logic wr_ready, tx, de, ack, done_flag;

  uart_tx_de #(.DIV_W(DIV_W), .DE_W(DE_W)) u_uart_tx_de (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .tx_en_i(tx_en),
    .word_len_i(word_len), .par_en_i(par_en), .par_odd_i(par_odd), .two_stop_i(two_stop),
    .de_lead_i(de_lead), .de_lag_i(de_lag), .baud_div_i(baud_div),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .tx_o(tx), .de_o(de), .tx_en_ack_o(ack), .tx_done_o(done_flag)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  int b_wl, b_pen, b_podd, b_two, b_div, b_lead, b_lag;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int neff();
    return (b_div == 0) ? 1 : b_div;
  endfunction

  function automatic int wbits();
    return (b_wl == 1) ? 9 : (b_wl == 2) ? 7 : 8;
  endfunction

  task automatic exp_frame(input logic [8:0] d, output logic [11:0] fb, output int f);
    int w, ones;
    w = wbits();
    fb = '1;
    fb[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < w - 1; i++) ones += int'(d[i]);
    for (int i = 0; i < w; i++)
      fb[i+1] = (b_pen != 0 && i == w - 1) ? ((ones % 2 == 1) ^ (b_podd != 0)) : d[i];
    f = 1 + w + ((b_two != 0) ? 2 : 1);
  endtask

  task automatic setup();
    int cnt;
    @(negedge clk);
    en = 0; tx_en = 0;
    word_len = 2'(b_wl); par_en = (b_pen != 0); par_odd = (b_podd != 0);
    two_stop = (b_two != 0); de_lead = DE_W'(b_lead); de_lag = DE_W'(b_lag);
    baud_div = DIV_W'(b_div);
    repeat (3) @(negedge clk);
    en = 1; tx_en = 1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!ack && cnt < 100);
    check(cnt == neff() + 1, "R8 ack delay", cnt, neff() + 1);
  endtask

  task automatic write(input logic [8:0] d);
    forever begin
      @(negedge clk);
      if (wr_ready) begin
        wr_valid = 1; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
        break;
      end
    end
  endtask

  task automatic check_frame(input logic [8:0] d, input bit exp_tc, input int exp_gap);
    logic [11:0] fb;
    int f, n, w, gap, pos, cnt;
    bit txlow;
    string req;
    gap = 0; txlow = 0;
    while (!de) begin gap++; if (!tx) txlow = 1; @(negedge clk); end
    if (exp_gap >= 0) begin
      check(gap == exp_gap, (exp_gap == 1) ? "R7 gap" : "R9 gap", gap, exp_gap);
      check(!txlow, "R9 line high in gap", int'(txlow), 0);
    end
    cnt = 0;
    while (tx) begin cnt++; @(negedge clk); end
    check(cnt == b_lead, "R5 lead", cnt, b_lead);
    exp_frame(d, fb, f);
    n = neff(); w = wbits(); pos = 0;
    for (int k = 0; k < f; k++) begin
      if (k > w) req = "R3 stop";
      else if (k == w && b_pen != 0) req = "R2 parity";
      else req = "R1 bit";
      while (pos < k * n) begin @(negedge clk); pos++; end
      check(tx == fb[k], req, int'(tx), int'(fb[k]));
      while (pos < k * n + n - 1) begin @(negedge clk); pos++; end
      check(tx == fb[k], "R4 bit end", int'(tx), int'(fb[k]));
    end
    while (pos < f * n) begin @(negedge clk); pos++; end
    check(done_flag == exp_tc, "R10 done", int'(done_flag), int'(exp_tc));
    cnt = 0;
    while (de) begin cnt++; @(negedge clk); end
    check(cnt == b_lag, "R6 lag", cnt, b_lag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int idx;
    logic [8:0] d1, d2;
    repeat (3) @(negedge clk);
    check(tx == 1 && de == 0 && ack == 0 && done_flag == 0 && wr_ready == 0, "R11 reset state",
          int'({tx, de, ack, done_flag, wr_ready}), 16);
    rst_ni = 1;
    @(negedge clk);

    // sweep of formats, divisors and driver-enable timings
    idx = 0;
    for (int dv = 0; dv <= 2; dv += 2)
      for (int wl = 0; wl < 3; wl++)
        for (int pr = 0; pr < 3; pr++)
          for (int st = 0; st < 2; st++) begin
            b_div = dv; b_wl = wl; b_pen = (pr != 0) ? 1 : 0; b_podd = (pr == 2) ? 1 : 0;
            b_two = st; b_lead = (idx * 3) % 5; b_lag = (idx * 7) % 6;
            d1 = 9'((idx * 37 + 5) & 9'h1FF);
            d2 = 9'((idx * 101 + 300) & 9'h1FF);
            setup();
            fork
              begin check_frame(d1, 1'b0, -1); check_frame(d2, 1'b1, 1); end
              begin write(d1); write(d2); end
            join
            idx++;
          end

    // R10: accepted write clears completion; R13 ready low while a word waits
    check(done_flag == 1, "R10 done held", int'(done_flag), 1);
    b_div = 1; b_wl = 0; b_pen = 0; b_podd = 0; b_two = 0; b_lead = 2; b_lag = 1;
    setup();
    @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    check(ack == 0, "R8 ack falls", int'(ack), 0);
    write(9'h0A5);
    check(done_flag == 0, "R10 cleared by write", int'(done_flag), 0);
    check(wr_ready == 0, "R13 ready low while waiting", int'(wr_ready), 0);
    begin
      bit seen;
      seen = 0;
      repeat (20) begin @(negedge clk); if (de || !tx) seen = 1; end
      check(!seen, "R8 held without ack", int'(seen), 0);
    end
    check(wr_ready == 0, "R13 word still held", int'(wr_ready), 0);
    tx_en = 1;
    check_frame(9'h0A5, 1'b1, -1);

    // R9: low pulse on transmitter enable queues an idle frame
    b_div = 2; b_wl = 0; b_pen = 0; b_podd = 0; b_two = 0; b_lead = 2; b_lag = 3;
    setup();
    fork
      begin check_frame(9'h13C, 1'b0, -1); check_frame(9'h0C3, 1'b1, 10 * 2 + 2); end
      begin write(9'h13C); write(9'h0C3); end
      begin
        do @(negedge clk); while (tx);
        tx_en = 0;
        @(negedge clk);
        tx_en = 1;
      end
    join

    // R12: configuration changes while enabled are ignored
    b_div = 3; b_wl = 2; b_pen = 1; b_podd = 1; b_two = 1; b_lead = 1; b_lag = 2;
    setup();
    word_len = 2'b00; par_en = 0; two_stop = 0; de_lead = 7; de_lag = 0; baud_div = 1;
    fork
      check_frame(9'h0B5, 1'b1, -1);
      write(9'h0B5);
    join

    // R11: disable clears flags at once and discards work
    b_div = 2; b_wl = 0; b_pen = 0; b_podd = 0; b_two = 1; b_lead = 1; b_lag = 1;
    setup();
    fork
      check_frame(9'h055, 1'b1, -1);
      write(9'h055);
    join
    check(done_flag == 1, "R10 done after frame", int'(done_flag), 1);
    en = 0;
    #1;
    check(done_flag == 0 && ack == 0, "R11 flags cleared", int'({done_flag, ack}), 0);
    @(negedge clk);
    en = 1;
    repeat (8) @(negedge clk);
    write(9'h111);
    write(9'h122);
    do @(negedge clk); while (tx);
    en = 0;
    #1;
    check(tx == 1 && de == 0 && wr_ready == 0, "R11 outputs silenced", int'({tx, de, wr_ready}), 4);
    @(negedge clk);
    en = 1;
    #1;
    check(wr_ready == 1, "R11 waiting word discarded", int'(wr_ready), 1);
    begin
      bit seen;
      seen = 0;
      repeat (60) begin @(negedge clk); if (de || !tx) seen = 1; end
      check(!seen, "R11 no frame after re-enable", int'(seen), 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule